// File: doc/BRIEF.md
# Ternary Superset Sharer Code

This block holds the sharer record of one directory entry in compressed form. Node IDs are `ID_W = log2(NODES)` bits wide. The record is a word of `ID_W` ternary digits, and each digit says that the sharers have 0 in that bit position, have 1 there, or may have either value ("both"). A word with no "both" digit names a single node. A word with `i` "both" digits covers `2^i` nodes. That set is a superset of the true sharers, so some invalidations may go to nodes that hold no copy. Each digit is stored in two bits, which makes the record `2*ID_W` bits wide.

The directory controller can clear the record, overwrite it with one node, or merge a new node into it. When it needs invalidation targets, it starts a walk. The block then presents every covered node ID in turn on a valid/ready output, one per cycle while the consumer is ready. The final ID is flagged, and the block can optionally leave out one node, normally the requester. A build-time option numbers the nodes in reflected Gray code before they enter the record, and converts each ID back to plain binary before it is emitted. For some sharer patterns this gives a tighter superset.

Top module: `tsc_sharer_code`

## Requirements
- R1: After reset or a clear operation (`op_i` = 1), every digit holds the empty marker `10`, so `code_o` for 8 nodes is `101010`. A walk started on an empty record emits no ID.
- R2: A set operation (`op_i` = 2) replaces the record with the exact digits of `node_i`. Digit k sits at `code_o[2k+1:2k]`, with `00` meaning 0 and `01` meaning 1. A walk then emits that single ID with the last flag raised.
- R3: An add operation (`op_i` = 3) turns digit k into `11` ("both") wherever bit k of the new ID differs from a 0/1 digit. Digits that already hold `11` stay `11`, and all other digits are unchanged. An add on an empty record behaves as a set.
- R4: A walk emits each of the `2^i` covered IDs exactly once. The order is that of a counter whose bits are spread over the "both" positions, with the lowest "both" digit changing fastest.
- R5: `tgt_last_o` is high on the final emitted ID and low on every other one. The block goes idle on the cycle after that ID is accepted.
- R6: When exclusion is requested with the start pulse, the excluded ID is never emitted. The last flag then moves to the final ID that remains, and a record covering only the excluded node emits nothing.
- R7: While `tgt_valid_o` is high and `tgt_ready_i` is low, the valid signal, ID and last flag hold their values.
- R8: While a walk is in progress, and in a cycle where `enum_start_i` is high, the operation inputs are ignored. A start pulse during a walk is also ignored.
- R9: With `GRAY_EN` set, set and add work on Gray-coded IDs and each emitted ID is converted back to binary. For 8 nodes, adding node 1 and then node 2 yields `001101` and emits only 1 then 2, where binary numbering yields `001111` and emits 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | 0 none, 1 clear, 2 set, 3 add |
| node_i | input | ID_W | Node ID for set or add |
| enum_start_i | input | 1 | Start a walk over the covered IDs |
| excl_en_i | input | 1 | Leave out `excl_id_i` during this walk |
| excl_id_i | input | ID_W | Node ID to leave out |
| code_o | output | 2*ID_W | Stored ternary record |
| busy_o | output | 1 | Walk in progress |
| tgt_valid_o | output | 1 | An emitted ID is present |
| tgt_ready_i | input | 1 | Consumer accepts the present ID |
| tgt_id_o | output | ID_W | Emitted node ID, binary |
| tgt_last_o | output | 1 | Present ID is the final one |

## Verification
A wrong digit after a set or add shows on `code_o` one cycle after the operation. It also changes the count or the values of the IDs emitted by the next walk. A fault in the walk counter or the skip logic shows up as a repeated, missing or out-of-order ID, or as a last flag in the wrong place. The bench catches these by comparing the whole emitted list against an expected list. Loss of state under back-pressure appears as a change in the held ID before the consumer accepts it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2,
        OP_ADD   = 2'd3
    } tsc_op_e;

    localparam logic [1:0] DIG_ZERO  = 2'b00;
    localparam logic [1:0] DIG_ONE   = 2'b01;
    localparam logic [1:0] DIG_BOTH  = 2'b11;
    localparam logic [1:0] DIG_EMPTY = 2'b10;
endpackage

// File: rtl/tsc_gray_map.sv
module tsc_gray_map #(
    parameter int W       = 4,
    parameter bit ENABLE  = 1'b0,
    parameter bit TO_GRAY = 1'b1
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    generate
        if (!ENABLE) begin : g_pass
            assign out_o = in_i;
        end else if (TO_GRAY) begin : g_enc
            assign out_o = in_i ^ (in_i >> 1);
        end else begin : g_dec
            for (genvar k = 0; k < W; k++) begin : g_bit
                assign out_o[k] = ^(in_i >> k);
            end
        end
    endgenerate
endmodule

// File: rtl/tsc_expand.sv
module tsc_expand
    import tsc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2*W-1:0] code_i,
    input  logic [W-1:0]   idx_i,
    output logic [W-1:0]   id_o
);
    // Spread the walk index over the "both" digits, lowest digit first.
    always_comb begin
        int j;
        j = 0;
        id_o = '0;
        for (int k = 0; k < W; k++) begin
            if (code_i[2*k +: 2] == DIG_BOTH) begin
                id_o[k] = idx_i[j];
                j = j + 1;
            end else begin
                id_o[k] = code_i[2*k];
            end
        end
    end
endmodule

// File: rtl/tsc_sharer_code.sv
module tsc_sharer_code
    import tsc_pkg::*;
#(
    parameter int NODES   = 16,
    parameter bit GRAY_EN = 1'b0,
    localparam int ID_W   = $clog2(NODES),
    localparam int CODE_W = 2 * ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [ID_W-1:0]   node_i,
    input  logic              enum_start_i,
    input  logic              excl_en_i,
    input  logic [ID_W-1:0]   excl_id_i,
    output logic [CODE_W-1:0] code_o,
    output logic              busy_o,
    output logic              tgt_valid_o,
    input  logic              tgt_ready_i,
    output logic [ID_W-1:0]   tgt_id_o,
    output logic              tgt_last_o
);
    localparam int CNT_W = ID_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic              xen;
        logic [ID_W-1:0]   xid;
        logic [CODE_W-1:0] code;
    } state_t;

    state_t s_d, s_q;

    logic [ID_W-1:0]  node_g, excl_g, cur_g, nxt_g, top_g, emit_g;
    logic [CNT_W-1:0] nboth, cnt_max, nxt_idx, emit_idx;
    logic             empty, cur_hit, top_hit, at_max, em_valid, em_last;

    tsc_gray_map #(.W(ID_W), .ENABLE(GRAY_EN), .TO_GRAY(1'b1)) u_map_node (
        .in_i(node_i), .out_o(node_g));
    tsc_gray_map #(.W(ID_W), .ENABLE(GRAY_EN), .TO_GRAY(1'b1)) u_map_excl (
        .in_i(excl_id_i), .out_o(excl_g));
    tsc_gray_map #(.W(ID_W), .ENABLE(GRAY_EN), .TO_GRAY(1'b0)) u_map_out (
        .in_i(emit_g), .out_o(tgt_id_o));

    assign nxt_idx = s_q.cnt + CNT_ONE;

    tsc_expand #(.W(ID_W)) u_exp_cur (
        .code_i(s_q.code), .idx_i(s_q.cnt[ID_W-1:0]), .id_o(cur_g));
    tsc_expand #(.W(ID_W)) u_exp_nxt (
        .code_i(s_q.code), .idx_i(nxt_idx[ID_W-1:0]), .id_o(nxt_g));
    tsc_expand #(.W(ID_W)) u_exp_top (
        .code_i(s_q.code), .idx_i(cnt_max[ID_W-1:0]), .id_o(top_g));

    always_comb begin
        nboth = '0;
        for (int k = 0; k < ID_W; k++) begin
            if (s_q.code[2*k +: 2] == DIG_BOTH) begin
                nboth = nboth + CNT_ONE;
            end
        end
        cnt_max  = (CNT_ONE << nboth) - CNT_ONE;
        empty    = (s_q.code[1:0] == DIG_EMPTY);
        cur_hit  = s_q.xen && (cur_g == s_q.xid);
        top_hit  = s_q.xen && (top_g == s_q.xid);
        at_max   = (s_q.cnt == cnt_max);
        em_valid = s_q.active && !(cur_hit && at_max);
        emit_g   = cur_hit ? nxt_g : cur_g;
        emit_idx = cur_hit ? nxt_idx : s_q.cnt;
        em_last  = (emit_idx == cnt_max) ||
                   (top_hit && ((emit_idx + CNT_ONE) == cnt_max));
    end

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            if (!em_valid) begin
                s_d.active = 1'b0;
            end else if (tgt_ready_i) begin
                if (em_last) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.cnt = emit_idx + CNT_ONE;
                end
            end
        end else if (enum_start_i) begin
            if (!empty) begin
                s_d.active = 1'b1;
                s_d.cnt    = '0;
                s_d.xen    = excl_en_i;
                s_d.xid    = excl_g;
            end
        end else begin
            case (tsc_op_e'(op_i))
                OP_CLEAR: s_d.code = {ID_W{DIG_EMPTY}};
                OP_SET: begin
                    for (int k = 0; k < ID_W; k++) begin
                        s_d.code[2*k +: 2] = node_g[k] ? DIG_ONE : DIG_ZERO;
                    end
                end
                OP_ADD: begin
                    for (int k = 0; k < ID_W; k++) begin
                        if (empty) begin
                            s_d.code[2*k +: 2] = node_g[k] ? DIG_ONE : DIG_ZERO;
                        end else if (s_q.code[2*k +: 2] != DIG_BOTH &&
                                     s_q.code[2*k] != node_g[k]) begin
                            s_d.code[2*k +: 2] = DIG_BOTH;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.cnt    <= '0;
            s_q.xen    <= 1'b0;
            s_q.xid    <= '0;
            s_q.code   <= {ID_W{DIG_EMPTY}};
        end else begin
            s_q <= s_d;
        end
    end

    assign code_o      = s_q.code;
    assign busy_o      = s_q.active;
    assign tgt_valid_o = em_valid;
    assign tgt_last_o  = em_last;

    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid_o && !tgt_ready_i |=>
            tgt_valid_o && $stable(tgt_id_o) && $stable(tgt_last_o));

    a_r5_last_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid_o && tgt_ready_i && tgt_last_o |=> !busy_o);

    a_r8_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(code_o));

    a_r1_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        code_o[1:0] == DIG_EMPTY |-> !tgt_valid_o);

    a_r6_excluded_absent: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid_o && s_q.xen |-> emit_g != s_q.xid);
endmodule

// File: tb/tsc_sharer_code_tb.sv
module tsc_sharer_code_tb;
    localparam int NODES = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [IW-1:0] nid = '0;
    logic          start_b = 1'b0, start_g = 1'b0;
    logic          xen = 1'b0;
    logic [IW-1:0] xid = '0;
    logic          ready = 1'b1;

    logic [2*IW-1:0] code_b, code_g;
    logic            busy_b, busy_g, vld_b, vld_g, last_b, last_g;
    logic [IW-1:0]   id_b, id_g;

    int errors = 0;
    int checks = 0;
    int got_n;
    int got_id [0:15];
    int got_last [0:15];
    int exp_id [0:15];

    always #5 clk = ~clk;

    tsc_sharer_code #(.NODES(NODES), .GRAY_EN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .node_i(nid),
        .enum_start_i(start_b), .excl_en_i(xen), .excl_id_i(xid),
        .code_o(code_b), .busy_o(busy_b), .tgt_valid_o(vld_b),
        .tgt_ready_i(ready), .tgt_id_o(id_b), .tgt_last_o(last_b));

    tsc_sharer_code #(.NODES(NODES), .GRAY_EN(1'b1)) u_dut_gray (
        .clk(clk), .rst_n(rst_n), .op_i(op), .node_i(nid),
        .enum_start_i(start_g), .excl_en_i(xen), .excl_id_i(xid),
        .code_o(code_g), .busy_o(busy_g), .tgt_valid_o(vld_g),
        .tgt_ready_i(ready), .tgt_id_o(id_g), .tgt_last_o(last_g));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] o, input int id);
        op = o; nid = IW'(id);
        @(negedge clk);
        op = 2'd0;
    endtask

    task automatic collect(input bit g);
        got_n = 0;
        ready = 1'b1;
        for (int c = 0; c < 40; c++) begin
            if (!(g ? busy_g : busy_b)) break;
            if (g ? vld_g : vld_b) begin
                got_id[got_n]   = int'(g ? id_g : id_b);
                got_last[got_n] = int'(g ? last_g : last_b);
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic walk(input bit g, input bit x, input int xi);
        xen = x; xid = IW'(xi);
        if (g) start_g = 1'b1; else start_b = 1'b1;
        @(negedge clk);
        start_g = 1'b0; start_b = 1'b0; xen = 1'b0;
        collect(g);
    endtask

    task automatic chk_list(input string tag, input int n);
        chk(got_n == n, {tag, " count"}, got_n, n);
        for (int k = 0; k < n && k < got_n; k++) begin
            chk(got_id[k] == exp_id[k], {tag, " id"}, got_id[k], exp_id[k]);
            chk(got_last[k] == int'(k == n - 1), {tag, " last"}, got_last[k], int'(k == n - 1));
        end
    endtask

    task automatic t_reset_clear;
        chk(code_b == 6'b101010, "R1 reset code", int'(code_b), 6'b101010);
        chk(!vld_b && !busy_b, "R1 reset idle", int'(vld_b), 0);
        do_op(2'd2, 3);
        do_op(2'd1, 0);
        chk(code_b == 6'b101010, "R1 clear code", int'(code_b), 6'b101010);
        walk(1'b0, 1'b0, 0);
        chk(got_n == 0, "R1 empty walk", got_n, 0);
    endtask

    task automatic t_set;
        do_op(2'd2, 5);
        chk(code_b == 6'b010001, "R2 set code", int'(code_b), 6'b010001);
        walk(1'b0, 1'b0, 0);
        exp_id[0] = 5;
        chk_list("R2 single", 1);
    endtask

    task automatic t_add;
        do_op(2'd1, 0);
        do_op(2'd3, 3);
        chk(code_b == 6'b000101, "R3 add to empty", int'(code_b), 6'b000101);
        do_op(2'd2, 4);
        do_op(2'd3, 6);
        chk(code_b == 6'b011100, "R3 add one diff", int'(code_b), 6'b011100);
        do_op(2'd3, 7);
        chk(code_b == 6'b011111, "R3 add second diff", int'(code_b), 6'b011111);
        do_op(2'd3, 5);
        chk(code_b == 6'b011111, "R3 both kept", int'(code_b), 6'b011111);
        walk(1'b0, 1'b0, 0);
        for (int k = 0; k < 4; k++) exp_id[k] = 4 + k;
        chk_list("R4 R5 four ids", 4);
        do_op(2'd2, 0);
        do_op(2'd3, 5);
        walk(1'b0, 1'b0, 0);
        exp_id[0] = 0; exp_id[1] = 1; exp_id[2] = 4; exp_id[3] = 5;
        chk_list("R4 split positions", 4);
    endtask

    task automatic t_excl;
        do_op(2'd2, 4);
        do_op(2'd3, 7);
        walk(1'b0, 1'b1, 7);
        exp_id[0] = 4; exp_id[1] = 5; exp_id[2] = 6;
        chk_list("R6 excl top", 3);
        walk(1'b0, 1'b1, 4);
        exp_id[0] = 5; exp_id[1] = 6; exp_id[2] = 7;
        chk_list("R6 excl first", 3);
        walk(1'b0, 1'b1, 5);
        exp_id[0] = 4; exp_id[1] = 6; exp_id[2] = 7;
        chk_list("R6 excl middle", 3);
        do_op(2'd2, 2);
        walk(1'b0, 1'b1, 2);
        chk(got_n == 0, "R6 only excluded", got_n, 0);
    endtask

    task automatic t_stall;
        do_op(2'd2, 4);
        do_op(2'd3, 7);
        ready = 1'b0;
        start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        chk(vld_b && id_b == 3'd4, "R7 first held", int'(id_b), 4);
        @(negedge clk);
        @(negedge clk);
        chk(vld_b && id_b == 3'd4 && !last_b, "R7 still held", int'(id_b), 4);
        do_op(2'd2, 0);
        start_b = 1'b1;
        @(negedge clk);
        start_b = 1'b0;
        chk(code_b == 6'b011111, "R8 op ignored busy", int'(code_b), 6'b011111);
        collect(1'b0);
        for (int k = 0; k < 4; k++) exp_id[k] = 4 + k;
        chk_list("R7 R8 after stall", 4);
        op = 2'd2; nid = 3'd1; start_b = 1'b1;
        @(negedge clk);
        op = 2'd0; start_b = 1'b0;
        chk(code_b == 6'b011111, "R8 op with start", int'(code_b), 6'b011111);
        collect(1'b0);
    endtask

    task automatic t_gray;
        do_op(2'd1, 0);
        do_op(2'd2, 1);
        do_op(2'd3, 2);
        chk(code_g == 6'b001101, "R9 gray code", int'(code_g), 6'b001101);
        chk(code_b == 6'b001111, "R9 binary code", int'(code_b), 6'b001111);
        walk(1'b1, 1'b0, 0);
        exp_id[0] = 1; exp_id[1] = 2;
        chk_list("R9 gray walk", 2);
        walk(1'b0, 1'b0, 0);
        for (int k = 0; k < 4; k++) exp_id[k] = k;
        chk_list("R9 binary walk", 4);
        walk(1'b1, 1'b1, 2);
        exp_id[0] = 1;
        chk_list("R9 gray excl", 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_clear();
        t_set();
        t_add();
        t_excl();
        t_stall();
        t_gray();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule